// File: doc/BRIEF.md
# PCI Configuration Cycle Translator

This block sits between a host-side request port and a simplified PCI configuration bus. A request names a device, a function, a byte offset into the configuration header, an access size (byte, halfword or dword), a direction, and for writes a right-aligned data value. The block turns the request into either a type-0 or a type-1 configuration address. It drives byte enables and byte-swapped write data, then waits a bounded time for the target to claim the cycle. It returns read data that is swapped back and right-aligned. If no target claims the cycle, the block returns all ones and records a sticky timeout.

The target bus number is not carried by the request. It comes from a bus-select field in a small control/status word. That word also shows whether the bridge sits in the host slot and holds the timeout flag. A separate selector addresses the bridge's own configuration header, whatever the bus-select field holds. Only one request is in flight at a time. `busy` covers it from acceptance to completion, and `respDone` marks the completion for one cycle.

Top module: `cfg_cycle_xlate`

## Requirements
- R1: `csrRdData` bit 13 equals `hostSlot`. While `hostSlot` is 0, an accepted request issues no bus cycle and completes with `respErr`=1 and `respData`=0xFFFFFFFF.
- R2: The size code is 0 for byte, 1 for halfword and 2 for dword. A misaligned request issues no bus cycle and completes with `respErr`=1 and `respData`=0xFFFFFFFF. Misaligned means a dword with a nonzero `reqOffset[1:0]`, a halfword with `reqOffset[0]`=1, or size code 3.
- R3: A request with `reqSelf`=0 and `reqDev` above 15 issues no bus cycle and completes with `respErr`=0 and `respData`=0xFFFFFFFF.
- R4: The bus-select field is `csrRdData[26:23]`. When it is 0, `cfgAddr` is a type-0 address with three parts: a one-hot bit at position 16+dev, the function in [10:8], and `reqOffset[7:2]` in [7:2]. Bits [15:11] and [1:0] are 0, so device 0 lands on AD16.
- R5: When the bus-select field is nonzero, `cfgAddr` is a type-1 address. It holds the bus number in [23:16], the device in [15:11], the function in [10:8] and `reqOffset[7:2]` in [7:2], with [1:0]=01.
- R6: With `reqSelf`=1, `cfgAddr` holds only `reqOffset[7:2]` in [7:2] and zeros elsewhere, whatever the bus-select field holds.
- R7: The host byte lane k is bits [8k+7:8k] of the host word. The host word is the sized write value shifted left by 8×`reqOffset[1:0]`. Bus data is the 32-bit byte reversal of the host word. `cfgByteEn` bit 3−k is 1 exactly for the host lanes the access covers, and this holds for reads and writes alike.
- R8: Read data is the byte reversal of `cfgRData`, shifted right by 8×`reqOffset[1:0]` and masked to the access size. A successful write completes with `respData`=0 and `respErr`=0.
- R9: The target has 5 active cycles, counted from the first active cycle, in which to raise `cfgDevsel`. A `cfgDevsel` in the 5th cycle still completes normally. With none in those 5 cycles, the request completes with `respData`=0xFFFFFFFF and `respErr`=0, and `csrRdData` bit 8 becomes 1.
- R10: A CSR write with `csrWrTmoClr`=1 clears bit 8. With `csrWrTmoClr`=0, bit 8 keeps its value. Every CSR write loads `csrWrBusSel` into bits [26:23].
- R11: `busy` rises the cycle after acceptance and stays high through the completion cycle. `respDone` is a one-cycle pulse, one cycle after the cycle in which `cfgDevsel` was seen. `cfgStart` marks only the first active cycle. A `reqValid` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSlot | input | 1 | Bridge is in the host slot |
| csrWrEn | input | 1 | Write strobe for the control/status word |
| csrWrBusSel | input | 4 | New bus-select value |
| csrWrTmoClr | input | 1 | Clear the timeout flag on this write |
| csrRdData | output | 32 | Control/status word |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqWrite | input | 1 | 1 for a write |
| reqSelf | input | 1 | Address the bridge's own header |
| reqDev | input | 5 | Device number |
| reqFunc | input | 3 | Function number |
| reqOffset | input | 8 | Byte offset in the header |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 dword |
| reqWData | input | 32 | Right-aligned write value |
| busy | output | 1 | Request in flight |
| respDone | output | 1 | Completion pulse |
| respData | output | 32 | Right-aligned read result |
| respErr | output | 1 | Request rejected |
| cfgStart | output | 1 | First cycle of the bus cycle |
| cfgActive | output | 1 | Bus cycle in progress |
| cfgWrite | output | 1 | Bus cycle direction |
| cfgAddr | output | 32 | Configuration address |
| cfgByteEn | output | 4 | Active-high byte enables |
| cfgWData | output | 32 | Bus write data |
| cfgDevsel | input | 1 | Target claims the cycle |
| cfgRData | input | 32 | Bus read data |

## Verification
The bench goes after the off-by-one at the timeout edge. It uses a target that answers in the 5th active cycle, which must succeed, and one that answers in the 6th, which must abort. A counter that is one cycle short or long flips one of these results. It checks sub-dword lanes at every offset parity. A design that swaps after shifting, or that does not reverse the byte enables, shows wrong bus lanes or wrong returned bytes. It also covers three further cases:
- a rejected request, which must raise no bus cycle;
- a request pulsed while busy, which a design without the guard would answer twice;
- the bridge selector, which must ignore a nonzero bus field.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic loadBus;
    logic loadOnes;
    logic setTimeout;
    logic errVal;
  } ctrlStrb_t;

  // request checks from datapath to control
  typedef struct packed {
    logic misaligned;
    logic noIssue;
  } reqChk_t;

  function automatic logic [31:0] swap32(input logic [31:0] w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = w[8*(3-b) +: 8];
    return r;
  endfunction

endpackage

// File: rtl/cfgx_dpath.sv
module cfgx_dpath
  import cfgx_pkg::*;
#(
  parameter int BUS_W    = 4,
  parameter int BUS_LSB  = 23,
  parameter int HOST_BIT = 13,
  parameter int TMO_BIT  = 8,
  parameter int DEV_MAX  = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  output reqChk_t          chk,
  input  logic             hostSlot,
  input  logic             csrWrEn,
  input  logic [BUS_W-1:0] csrWrBusSel,
  input  logic             csrWrTmoClr,
  output logic [31:0]      csrRdData,
  input  logic             reqWrite,
  input  logic             reqSelf,
  input  logic [4:0]       reqDev,
  input  logic [2:0]       reqFunc,
  input  logic [7:0]       reqOffset,
  input  logic [1:0]       reqSize,
  input  logic [31:0]      reqWData,
  output logic             cfgWrite,
  output logic [31:0]      cfgAddr,
  output logic [3:0]       cfgByteEn,
  output logic [31:0]      cfgWData,
  input  logic [31:0]      cfgRData,
  output logic [31:0]      respData,
  output logic             respErr
);

  localparam int BUS_PAD = 8 - BUS_W;

  logic [BUS_W-1:0] busSel;
  logic             tmoFlag;
  logic [1:0]       lOff;
  logic [1:0]       lSize;

  logic [1:0]  off;
  logic [5:0]  regIdx;
  logic [3:0]  hostLanes;
  logic [3:0]  busLanes;
  logic [31:0] sizedW;
  logic [31:0] hostWord;
  logic [31:0] nextAddr;
  logic [15:0] idsel;
  logic [31:0] hostRd;
  logic [31:0] shiftedRd;
  logic [31:0] extractRd;

  assign off    = reqOffset[1:0];
  assign regIdx = reqOffset[7:2];

  always_comb begin
    chk.misaligned = (reqSize == SZ_WORD && off != 2'b00) ||
                     (reqSize == SZ_HALF && off[0]) ||
                     (reqSize == 2'd3);
    chk.noIssue    = !reqSelf && (reqDev > 5'(DEV_MAX));
  end

  always_comb begin
    case (reqSize)
      SZ_BYTE: begin hostLanes = 4'b0001 << off; sizedW = {24'b0, reqWData[7:0]};  end
      SZ_HALF: begin hostLanes = 4'b0011 << off; sizedW = {16'b0, reqWData[15:0]}; end
      default: begin hostLanes = 4'b1111;        sizedW = reqWData;                end
    endcase
    hostWord = sizedW << {off, 3'b000};
  end

  // bus lane 3-k carries host lane k
  for (genvar k = 0; k < 4; k++) begin : g_laneRev
    assign busLanes[3-k] = hostLanes[k];
  end

  always_comb begin
    idsel = 16'b1 << reqDev[3:0];
    if (reqSelf)
      nextAddr = {24'b0, regIdx, 2'b00};
    else if (busSel == '0)
      nextAddr = {idsel, 5'b0, reqFunc, regIdx, 2'b00};
    else
      nextAddr = {8'b0, {BUS_PAD{1'b0}}, busSel, reqDev, reqFunc, regIdx, 2'b01};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAddr   <= '0;
      cfgByteEn <= '0;
      cfgWData  <= '0;
      cfgWrite  <= 1'b0;
      lOff      <= '0;
      lSize     <= '0;
    end else if (strb.latchReq) begin
      cfgAddr   <= nextAddr;
      cfgByteEn <= busLanes;
      cfgWData  <= swap32(hostWord);
      cfgWrite  <= reqWrite;
      lOff      <= off;
      lSize     <= reqSize;
    end
  end

  always_comb begin
    hostRd    = swap32(cfgRData);
    shiftedRd = hostRd >> {lOff, 3'b000};
    case (lSize)
      SZ_BYTE: extractRd = {24'b0, shiftedRd[7:0]};
      SZ_HALF: extractRd = {16'b0, shiftedRd[15:0]};
      default: extractRd = shiftedRd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respData <= '0;
      respErr  <= 1'b0;
    end else if (strb.loadOnes) begin
      respData <= '1;
      respErr  <= strb.errVal;
    end else if (strb.loadBus) begin
      respData <= cfgWrite ? '0 : extractRd;
      respErr  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busSel  <= '0;
      tmoFlag <= 1'b0;
    end else begin
      if (csrWrEn) busSel <= csrWrBusSel;
      if (strb.setTimeout) tmoFlag <= 1'b1;
      else if (csrWrEn && csrWrTmoClr) tmoFlag <= 1'b0;
    end
  end

  always_comb begin
    csrRdData = '0;
    csrRdData[BUS_LSB +: BUS_W] = busSel;
    csrRdData[HOST_BIT]         = hostSlot;
    csrRdData[TMO_BIT]          = tmoFlag;
  end

  AST_TMO_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tmoFlag) |-> $past(strb.setTimeout)) else $error("tmo"); // R9
  AST_ONES_ON_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadOnes |=> (respData == 32'hFFFF_FFFF)) else $error("ones"); // R3
  AST_BE_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchReq && !chk.misaligned) |=> (cfgByteEn != 4'b0000)) else $error("be"); // R7

endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
#(
  parameter int TMO_CYCLES = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      hostSlot,
  input  reqChk_t   chk,
  input  logic      cfgDevsel,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      respDone,
  output logic      cfgStart,
  output logic      cfgActive
);

  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_FIN} state_e;

  state_e        state, stateNxt;
  logic [CW-1:0] cnt, cntNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    cntNxt   = cnt;
    case (state)
      ST_IDLE: begin
        cntNxt = '0;
        if (reqValid) begin
          strb.latchReq = 1'b1;
          if (!hostSlot || chk.misaligned) begin
            strb.loadOnes = 1'b1;
            strb.errVal   = 1'b1;
            stateNxt      = ST_FIN;
          end else if (chk.noIssue) begin
            strb.loadOnes = 1'b1;
            stateNxt      = ST_FIN;
          end else begin
            stateNxt = ST_ACT;
          end
        end
      end
      ST_ACT: begin
        if (cfgDevsel) begin
          strb.loadBus = 1'b1;
          stateNxt     = ST_FIN;
        end else if (cnt == LAST) begin
          strb.loadOnes   = 1'b1;
          strb.setTimeout = 1'b1;
          stateNxt        = ST_FIN;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign respDone  = (state == ST_FIN);
  assign cfgActive = (state == ST_ACT);
  assign cfgStart  = cfgActive && (cnt == '0);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone) else $error("done"); // R11
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cfgStart |=> !cfgStart) else $error("start"); // R11
  AST_NO_CYCLE_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && chk.misaligned) |=> !cfgActive) else $error("rej"); // R2
  AST_NO_CYCLE_NOHOST: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && !hostSlot) |=> !cfgActive) else $error("host"); // R1

endmodule

// File: rtl/cfg_cycle_xlate.sv
module cfg_cycle_xlate
  import cfgx_pkg::*;
#(
  parameter int TMO_CYCLES = 5,
  parameter int BUS_W      = 4,
  parameter int BUS_LSB    = 23,
  parameter int HOST_BIT   = 13,
  parameter int TMO_BIT    = 8,
  parameter int DEV_MAX    = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostSlot,
  input  logic             csrWrEn,
  input  logic [BUS_W-1:0] csrWrBusSel,
  input  logic             csrWrTmoClr,
  output logic [31:0]      csrRdData,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqSelf,
  input  logic [4:0]       reqDev,
  input  logic [2:0]       reqFunc,
  input  logic [7:0]       reqOffset,
  input  logic [1:0]       reqSize,
  input  logic [31:0]      reqWData,
  output logic             busy,
  output logic             respDone,
  output logic [31:0]      respData,
  output logic             respErr,
  output logic             cfgStart,
  output logic             cfgActive,
  output logic             cfgWrite,
  output logic [31:0]      cfgAddr,
  output logic [3:0]       cfgByteEn,
  output logic [31:0]      cfgWData,
  input  logic             cfgDevsel,
  input  logic [31:0]      cfgRData
);

  ctrlStrb_t strb;
  reqChk_t   chk;

  cfgx_ctrl #(.TMO_CYCLES(TMO_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hostSlot(hostSlot),
    .chk(chk), .cfgDevsel(cfgDevsel), .strb(strb), .busy(busy),
    .respDone(respDone), .cfgStart(cfgStart), .cfgActive(cfgActive)
  );

  cfgx_dpath #(
    .BUS_W(BUS_W), .BUS_LSB(BUS_LSB), .HOST_BIT(HOST_BIT),
    .TMO_BIT(TMO_BIT), .DEV_MAX(DEV_MAX)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .chk(chk), .hostSlot(hostSlot),
    .csrWrEn(csrWrEn), .csrWrBusSel(csrWrBusSel), .csrWrTmoClr(csrWrTmoClr),
    .csrRdData(csrRdData), .reqWrite(reqWrite), .reqSelf(reqSelf),
    .reqDev(reqDev), .reqFunc(reqFunc), .reqOffset(reqOffset),
    .reqSize(reqSize), .reqWData(reqWData), .cfgWrite(cfgWrite),
    .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn), .cfgWData(cfgWData),
    .cfgRData(cfgRData), .respData(respData), .respErr(respErr)
  );

endmodule

// File: tb/cfg_cycle_xlate_bench.sv
module cfg_cycle_xlate_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSlot = 1'b1;
  logic csrWrEn = 1'b0;
  logic [3:0] csrWrBusSel = '0;
  logic csrWrTmoClr = 1'b0;
  logic [31:0] csrRdData;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqSelf = 1'b0;
  logic [4:0] reqDev = '0;
  logic [2:0] reqFunc = '0;
  logic [7:0] reqOffset = '0;
  logic [1:0] reqSize = '0;
  logic [31:0] reqWData = '0;
  logic busy, respDone, respErr, cfgStart, cfgActive, cfgWrite;
  logic [31:0] respData, cfgAddr, cfgWData;
  logic [3:0] cfgByteEn;
  logic cfgDevsel = 1'b0;
  logic [31:0] cfgRData;

  always #10 clk = ~clk;

  cfg_cycle_xlate u_cfg_cycle_xlate (.*);

  // target model
  logic tgtPresent = 1'b1;
  int tgtDelay = 0;
  int actCnt = 0;
  logic [31:0] tgtData = 32'h1122_3344;
  assign cfgRData = tgtData;

  always @(negedge clk) begin
    if (cfgActive) begin
      cfgDevsel <= tgtPresent && (actCnt == tgtDelay);
      actCnt <= actCnt + 1;
    end else begin
      cfgDevsel <= 1'b0;
      actCnt <= 0;
    end
  end

  typedef struct { logic [31:0] data; logic err; string tag; } resp_t;
  typedef struct { logic [31:0] addr; logic [3:0] be; logic [31:0] wd; logic wr; string tag; } busItem_t;
  resp_t respQ[$];
  busItem_t busQ[$];

  int nChecks = 0, nFails = 0;
  int lastLat = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [3:0] hostLanes(input logic [1:0] sz, input logic [1:0] o);
    if (sz == 2'd0) return 4'b0001 << o;
    if (sz == 2'd1) return 4'b0011 << o;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] sizeMask(input logic [1:0] sz);
    if (sz == 2'd0) return 32'hFF;
    if (sz == 2'd1) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rstN && respDone) begin
      if (respQ.size() == 0) check(0, "R11 unexpected completion", respData, 0);
      else begin
        resp_t e;
        e = respQ.pop_front();
        check(respData == e.data, {e.tag, " data"}, respData, e.data);
        check(respErr == e.err, {e.tag, " err"}, {31'b0, respErr}, {31'b0, e.err});
      end
    end
    if (rstN && cfgStart) begin
      if (busQ.size() == 0) check(0, "R2 R3 R1 unexpected bus cycle", cfgAddr, 0);
      else begin
        busItem_t b;
        b = busQ.pop_front();
        check(cfgAddr == b.addr, {b.tag, " addr"}, cfgAddr, b.addr);
        check(cfgByteEn == b.be, {b.tag, " be"}, {28'b0, cfgByteEn}, {28'b0, b.be});
        check(cfgWrite == b.wr, {b.tag, " dir"}, {31'b0, cfgWrite}, {31'b0, b.wr});
        if (b.wr) check(cfgWData == b.wd, {b.tag, " wdata"}, cfgWData, b.wd);
      end
    end
  end

  task automatic drive(input bit wr, input bit self, input logic [4:0] dev, input logic [2:0] fn,
                       input logic [7:0] off, input logic [1:0] sz, input logic [31:0] wd);
    reqWrite = wr; reqSelf = self; reqDev = dev; reqFunc = fn;
    reqOffset = off; reqSize = sz; reqWData = wd; reqValid = 1'b1;
  endtask

  // push expectations; issue and wait for completion
  task automatic doReq(input string tag, input bit wr, input bit self, input logic [4:0] dev,
                       input logic [2:0] fn, input logic [7:0] off, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [3:0] busN, input bit expRej,
                       input bit expNoIssue, input bit expAbort);
    resp_t r;
    busItem_t b;
    logic [3:0] hl;
    r.tag = tag; b.tag = tag;
    if (expRej) begin r.data = '1; r.err = 1'b1; end
    else if (expNoIssue || expAbort) begin r.data = '1; r.err = 1'b0; end
    else begin
      r.err = 1'b0;
      r.data = wr ? 32'h0 : ((swap32(tgtData) >> (8 * off[1:0])) & sizeMask(sz));
    end
    respQ.push_back(r);
    if (!expRej && !expNoIssue) begin
      if (self) b.addr = {24'b0, off[7:2], 2'b00};
      else if (busN == 0) b.addr = (32'h1 << (16 + dev)) | (32'(fn) << 8) | {24'b0, off[7:2], 2'b00};
      else b.addr = (32'(busN) << 16) | (32'(dev) << 11) | (32'(fn) << 8) | {24'b0, off[7:2], 2'b01};
      hl = hostLanes(sz, off[1:0]);
      b.be = {hl[0], hl[1], hl[2], hl[3]};
      b.wd = swap32((wd & sizeMask(sz)) << (8 * off[1:0]));
      b.wr = wr;
      busQ.push_back(b);
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    drive(wr, self, dev, fn, off, sz, wd);
    @(negedge clk);
    reqValid = 1'b0;
    lastLat = 1;
    while (!respDone) begin @(negedge clk); lastLat++; end
  endtask

  task automatic csrWrite(input logic [3:0] bs, input bit clr);
    @(negedge clk);
    csrWrEn = 1'b1; csrWrBusSel = bs; csrWrTmoClr = clr;
    @(negedge clk);
    csrWrEn = 1'b0; csrWrTmoClr = 1'b0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(busy == 0, "R11 reset busy", {31'b0, busy}, 0);
    check(respDone == 0, "R11 reset done", {31'b0, respDone}, 0);
    check(csrRdData == 32'h0000_2000, "R1 reset csr", csrRdData, 32'h0000_2000);

    // type-0 reads and writes
    doReq("R4 type0 dword read", 0, 0, 5'd3, 3'd2, 8'h10, 2'd2, 0, 0, 0, 0, 0);
    doReq("R4 type0 dev0", 0, 0, 5'd0, 3'd0, 8'h00, 2'd2, 0, 0, 0, 0, 0);
    doReq("R8 byte read off1", 0, 0, 5'd1, 3'd0, 8'h11, 2'd0, 0, 0, 0, 0, 0);
    doReq("R8 byte read off3", 0, 0, 5'd1, 3'd0, 8'h13, 2'd0, 0, 0, 0, 0, 0);
    doReq("R8 half read off2", 0, 0, 5'd15, 3'd7, 8'h3E, 2'd1, 0, 0, 0, 0, 0);
    doReq("R7 byte write off1", 1, 0, 5'd2, 3'd1, 8'h0D, 2'd0, 32'hFFFF_FFA5, 0, 0, 0, 0);
    doReq("R7 half write off2", 1, 0, 5'd2, 3'd1, 8'h0E, 2'd1, 32'h1234_BEEF, 0, 0, 0, 0);
    doReq("R7 dword write", 1, 0, 5'd4, 3'd0, 8'h04, 2'd2, 32'hDEAD_BEEF, 0, 0, 0, 0);

    // bus select field and type-1
    csrWrite(4'd3, 0);
    check(csrRdData == 32'h0180_2000, "R10 bus field", csrRdData, 32'h0180_2000);
    tgtData = 32'hA1B2_C3D4;
    doReq("R5 type1 read", 0, 0, 5'd9, 3'd5, 8'h08, 2'd2, 0, 4'd3, 0, 0, 0);
    doReq("R5 type1 dev above 15", 0, 0, 5'd20, 3'd0, 8'h00, 2'd2, 0, 4'd3, 0, 1, 0);
    doReq("R6 self header", 0, 1, 5'd7, 3'd3, 8'h3C, 2'd2, 0, 4'd3, 0, 0, 0);
    csrWrite(4'd0, 0);

    // not issued / rejected
    doReq("R3 dev16", 0, 0, 5'd16, 3'd0, 8'h00, 2'd2, 0, 0, 0, 1, 0);
    doReq("R2 dword misaligned", 0, 0, 5'd1, 3'd0, 8'h02, 2'd2, 0, 0, 1, 0, 0);
    doReq("R2 half odd", 1, 0, 5'd1, 3'd0, 8'h05, 2'd1, 32'h55, 0, 1, 0, 0);
    check(csrRdData[8] == 0, "R2 no timeout from reject", {31'b0, csrRdData[8]}, 0);

    // timeout window
    tgtDelay = 2;
    doReq("R11 latency delay2", 0, 0, 5'd6, 3'd0, 8'h20, 2'd2, 0, 0, 0, 0, 0);
    check(lastLat == 4, "R11 done cycle", lastLat, 4);
    tgtDelay = 4;
    doReq("R9 devsel in 5th", 0, 0, 5'd6, 3'd0, 8'h20, 2'd2, 0, 0, 0, 0, 0);
    check(csrRdData[8] == 0, "R9 no tmo on 5th", {31'b0, csrRdData[8]}, 0);
    tgtDelay = 5;
    doReq("R9 devsel in 6th aborts", 0, 0, 5'd6, 3'd0, 8'h20, 2'd2, 0, 0, 0, 0, 1);
    check(csrRdData[8] == 1, "R9 tmo set", {31'b0, csrRdData[8]}, 1);
    check(lastLat == 6, "R9 abort cycle", lastLat, 6);
    tgtPresent = 0; tgtDelay = 0;
    doReq("R9 absent target", 1, 0, 5'd8, 3'd0, 8'h40, 2'd2, 32'h1, 0, 0, 0, 1);
    csrWrite(4'd0, 0);
    check(csrRdData[8] == 1, "R10 write 0 keeps tmo", {31'b0, csrRdData[8]}, 1);
    csrWrite(4'd0, 1);
    check(csrRdData[8] == 0, "R10 w1c clears tmo", {31'b0, csrRdData[8]}, 0);
    tgtPresent = 1;

    // request while busy is ignored
    tgtDelay = 3;
    begin
      resp_t r;
      busItem_t b;
      r.tag = "R11 busy ignore"; r.err = 0;
      r.data = swap32(tgtData);
      respQ.push_back(r);
      b.tag = "R11 busy ignore"; b.addr = 32'h0020_0000; b.be = 4'hF; b.wd = 0; b.wr = 0;
      busQ.push_back(b);
      @(negedge clk);
      drive(0, 0, 5'd5, 3'd0, 8'h00, 2'd2, 0);
      @(negedge clk);
      check(busy == 1, "R11 busy after accept", {31'b0, busy}, 1);
      drive(1, 0, 5'd16, 3'd0, 8'h00, 2'd2, 0);
      @(negedge clk);
      reqValid = 1'b0;
      while (!respDone) @(negedge clk);
      repeat (4) @(negedge clk);
    end
    tgtDelay = 0;

    // not in host slot
    hostSlot = 0;
    @(negedge clk);
    check(csrRdData[13] == 0, "R1 host bit low", {31'b0, csrRdData[13]}, 0);
    doReq("R1 no host slot", 0, 0, 5'd1, 3'd0, 8'h00, 2'd2, 0, 0, 1, 0, 0);
    hostSlot = 1;

    repeat (5) @(negedge clk);
    check(respQ.size() == 0, "R11 all responses seen", respQ.size(), 0);
    check(busQ.size() == 0, "R4 all bus cycles seen", busQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule